// File: doc/BRIEF.md
# Condition Register Field Transfer Unit

This block owns a 32-bit condition register split into eight 4-bit fields and carries out the moves between that register and a 64-bit general-register operand. One operation is applied per clock. Register updates land on the rising edge when the write qualifier is high. The 64-bit result is combinational and is always computed from the register contents held before that edge.

Five moves are supported. The first writes every field selected by an 8-bit mask from the source operand. The second writes exactly one field, picked by priority from the mask. The third reads exactly one field, picked the same way, into an otherwise zero result. The fourth reads the whole register zero-extended. The fifth packs four overflow and carry flags into a field chosen by a 3-bit index. In the 64-bit view, bits are numbered from the most significant end, and field n occupies positions 4n+32 to 4n+35. Field 0 is therefore bits [31:28] in little-endian vector terms and field 7 is bits [3:0]. Mask bit for field n is `fld_mask[7-n]`, so the mask MSB corresponds to field 0.

Top module: `crf_xfer_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is cleared to zero. A full read after reset returns 0.
- R2: Op code 0 (masked write) with `wr_en` high replaces each field n with `fld_mask[7-n]`=1 by `src_opnd` bits [31-4n:28-4n]. All other fields are left unchanged.
- R3: Op code 1 (single write) with `wr_en` high updates only the lowest-numbered field whose mask bit is set, taking that field's bits from `src_opnd`. When the mask is all zero, field 7 (bits [3:0]) is written.
- R4: Op code 2 (single read) returns zero everywhere except the lowest-numbered field with its mask bit set. That field is copied to its own position, result bits [31-4n:28-4n].
- R5: Op code 2 with an all-zero mask returns a 64-bit zero.
- R6: Op code 3 (full read) returns 32 zero bits in [63:32] and the register in [31:0].
- R7: Op code 4 (flag copy) with `wr_en` high writes field `fld_idx` with {`flag_ov`, `flag_ov32`, `flag_ca`, `flag_ca32`}, with `flag_ov` in the field MSB. Other fields are unchanged.
- R8: The register does not change when `wr_en` is low, or when the op is a read (2, 3) or an unused code (5 to 7). Write ops (0, 1, 4) and unused codes return a zero result.
- R9: The result for a read reflects the register as it stood before the edge. A write becomes visible only on reads in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Qualifies register updates this cycle |
| op_sel | input | 3 | Operation code (0 to 4 used) |
| fld_mask | input | 8 | Field mask, MSB selects field 0 |
| fld_idx | input | 3 | Field index for flag copy |
| src_opnd | input | 64 | Source general-register operand |
| flag_ov | input | 1 | Overflow flag |
| flag_ov32 | input | 1 | 32-bit overflow flag |
| flag_ca | input | 1 | Carry flag |
| flag_ca32 | input | 1 | 32-bit carry flag |
| result | output | 64 | Combinational move result |

## Verification
The assertions assume that inputs are known (not X) whenever reset is released. They also assume that `op_sel` is sampled only as an encoded value, with codes 5 to 7 treated as no-ops. The immediate checks on the priority picker skip evaluation while the mask is unknown.

The stimulus drives every input at the falling edge, so values are stable at each rising edge. It draws op codes across all eight values, including the unused ones. Masks are biased toward zero, single-bit and all-ones patterns so that the priority and default paths are exercised often. `wr_en` is held mostly high.

// File: rtl/crf_pkg.sv
// Package: shared constants and the operation encoding of the condition
// register field transfer unit. Assumes 4-bit fields, fixed by the flag pack.
package crf_pkg;

    localparam int CRF_FIELD_W = 4;
    localparam int CRF_OP_W    = 3;

    typedef enum logic [CRF_OP_W-1:0] {
        CRF_OP_MASK_WR = 3'd0,
        CRF_OP_ONE_WR  = 3'd1,
        CRF_OP_ONE_RD  = 3'd2,
        CRF_OP_FULL_RD = 3'd3,
        CRF_OP_FLAG_CP = 3'd4,
        CRF_OP_RSV5    = 3'd5,
        CRF_OP_RSV6    = 3'd6,
        CRF_OP_RSV7    = 3'd7
    } crf_op_e;

endpackage

// File: rtl/crf_field_pick.sv
// Module: crf_field_pick
// Turns a field mask into one-hot field selects, indexed by field number.
// Mask bit NUM_FIELDS-1 corresponds to field 0 (MSB-first numbering).
// sel_oh picks the lowest-numbered set field (all zero if none).
// wr_oh does the same, but falls back to the last field on an empty mask.
// Assumes: purely combinational, no state.
module crf_field_pick #(
    parameter int NUM_FIELDS = 8
) (
    input  logic [NUM_FIELDS-1:0] mask,
    output logic [NUM_FIELDS-1:0] sel_oh,
    output logic [NUM_FIELDS-1:0] wr_oh,
    output logic                  any_set
);

    logic [NUM_FIELDS-1:0] by_field;
    logic [NUM_FIELDS:0]   seen;

    assign seen[0] = 1'b0;

    genvar n;
    generate
        for (n = 0; n < NUM_FIELDS; n++) begin : g_chain
            // Reorder the mask so that index n is field n.
            assign by_field[n] = mask[NUM_FIELDS-1-n];
            // The first set field in ascending order wins.
            assign sel_oh[n]   = by_field[n] & ~seen[n];
            assign seen[n+1]   = seen[n] | by_field[n];
        end
    endgenerate

    assign any_set = seen[NUM_FIELDS];

    // Write select: the picked field, or the last field when nothing is set.
    always_comb begin
        wr_oh = sel_oh;
        if (!any_set) begin
            wr_oh[NUM_FIELDS-1] = 1'b1;
        end
    end

    // Check selector shape whenever the mask is a known value.
    always_comb begin
        if (!$isunknown(mask)) begin
            AST_PICK_ONEHOT0: assert ($onehot0(sel_oh)); // R4
            AST_WR_PICK_ONEHOT: assert ($onehot(wr_oh)); // R3
            AST_PICK_EMPTY: assert ((mask != '0) || (sel_oh == '0)); // R5
        end
    end

endmodule

// File: rtl/crf_next_state.sv
// Module: crf_next_state
// Computes the next condition register value from the op, the mask or index,
// the source operand and the packed flags.
// Non-write ops return the current value unchanged.
// Assumes: the field selects come from crf_field_pick; write qualification is
// applied by the caller.
module crf_next_state
    import crf_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int GPR_W      = 64,
    localparam int CR_W      = NUM_FIELDS * CRF_FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]        cr_q,
    input  crf_op_e                op,
    input  logic [NUM_FIELDS-1:0]  mask,
    input  logic [NUM_FIELDS-1:0]  wr_oh,
    input  logic [IDX_W-1:0]       idx,
    input  logic [GPR_W-1:0]       src,
    input  logic [CRF_FIELD_W-1:0] flags,
    output logic [CR_W-1:0]        cr_d,
    output logic                   is_write
);

    logic [NUM_FIELDS-1:0] fld_we;

    // Classify the op as a register-modifying one.
    always_comb begin
        unique case (op)
            CRF_OP_MASK_WR, CRF_OP_ONE_WR, CRF_OP_FLAG_CP: is_write = 1'b1;
            default:                                       is_write = 1'b0;
        endcase
    end

    genvar n;
    generate
        for (n = 0; n < NUM_FIELDS; n++) begin : g_fld
            localparam int HI = CR_W - 1 - CRF_FIELD_W * n;

            logic                   idx_hit;
            logic [CRF_FIELD_W-1:0] new_val;

            assign idx_hit = (idx == IDX_W'(n));

            // Per-field enable and replacement data for the active op.
            always_comb begin
                fld_we[n] = 1'b0;
                new_val   = src[HI -: CRF_FIELD_W];
                unique case (op)
                    CRF_OP_MASK_WR: fld_we[n] = mask[NUM_FIELDS-1-n];
                    CRF_OP_ONE_WR:  fld_we[n] = wr_oh[n];
                    CRF_OP_FLAG_CP: begin
                        fld_we[n] = idx_hit;
                        new_val   = flags;
                    end
                    default:        fld_we[n] = 1'b0;
                endcase
            end

            assign cr_d[HI -: CRF_FIELD_W] = fld_we[n] ? new_val
                                                       : cr_q[HI -: CRF_FIELD_W];
        end
    endgenerate

    // Single-field and flag forms touch at most one field; reads touch none.
    always_comb begin
        if (!$isunknown({op, wr_oh, idx})) begin
            AST_ONE_FIELD_EN: assert ((op == CRF_OP_MASK_WR) || $onehot0(fld_we)); // R3
            AST_READ_NO_EN: assert (is_write || (fld_we == '0)); // R8
        end
    end

endmodule

// File: rtl/crf_read_mux.sv
// Module: crf_read_mux
// Forms the 64-bit result from the current register contents.
// Single read keeps only the selected field, in its own position.
// Full read zero-extends the whole register.
// All other ops return zero.
// Assumes: sel_oh is one-hot or zero.
module crf_read_mux
    import crf_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int GPR_W      = 64,
    localparam int CR_W      = NUM_FIELDS * CRF_FIELD_W
) (
    input  logic [CR_W-1:0]       cr_q,
    input  crf_op_e               op,
    input  logic [NUM_FIELDS-1:0] sel_oh,
    output logic [GPR_W-1:0]      result
);

    logic [CR_W-1:0] keep_bits;
    logic [CR_W-1:0] one_fld;

    genvar n;
    generate
        for (n = 0; n < NUM_FIELDS; n++) begin : g_keep
            localparam int HI = CR_W - 1 - CRF_FIELD_W * n;
            // Expand each field select over that field's bits.
            assign keep_bits[HI -: CRF_FIELD_W] = {CRF_FIELD_W{sel_oh[n]}};
        end
    endgenerate

    assign one_fld = cr_q & keep_bits;

    // Choose the result by op; writes and unused codes yield zero.
    always_comb begin
        unique case (op)
            CRF_OP_ONE_RD:  result = {{(GPR_W-CR_W){1'b0}}, one_fld};
            CRF_OP_FULL_RD: result = {{(GPR_W-CR_W){1'b0}}, cr_q};
            default:        result = '0;
        endcase
    end

endmodule

// File: rtl/crf_xfer_unit.sv
// Module: crf_xfer_unit (top)
// Holds the condition register and performs the field transfer moves.
// The register updates on the rising edge when wr_en is high.
// The result is combinational from the pre-edge contents.
// Assumes: synchronous active-low reset; op codes 5 to 7 are no-ops.
module crf_xfer_unit
    import crf_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int GPR_W      = 64,
    localparam int CR_W      = NUM_FIELDS * CRF_FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CRF_OP_W-1:0]   op_sel,
    input  logic [NUM_FIELDS-1:0] fld_mask,
    input  logic [IDX_W-1:0]      fld_idx,
    input  logic [GPR_W-1:0]      src_opnd,
    input  logic                  flag_ov,
    input  logic                  flag_ov32,
    input  logic                  flag_ca,
    input  logic                  flag_ca32,
    output logic [GPR_W-1:0]      result
);

    crf_op_e                op;
    logic [CR_W-1:0]        cr_q;
    logic [CR_W-1:0]        cr_d;
    logic [CR_W-1:0]        cr_prev_q;
    logic [NUM_FIELDS-1:0]  sel_oh;
    logic [NUM_FIELDS-1:0]  wr_oh;
    logic                   any_set;
    logic                   is_write;
    logic [CRF_FIELD_W-1:0] flags;
    logic [NUM_FIELDS-1:0]  fld_diff;

    assign op    = crf_op_e'(op_sel);
    assign flags = {flag_ov, flag_ov32, flag_ca, flag_ca32};

    crf_field_pick #(
        .NUM_FIELDS (NUM_FIELDS)
    ) u_pick (
        .mask    (fld_mask),
        .sel_oh  (sel_oh),
        .wr_oh   (wr_oh),
        .any_set (any_set)
    );

    crf_next_state #(
        .NUM_FIELDS (NUM_FIELDS),
        .GPR_W      (GPR_W)
    ) u_next (
        .cr_q     (cr_q),
        .op       (op),
        .mask     (fld_mask),
        .wr_oh    (wr_oh),
        .idx      (fld_idx),
        .src      (src_opnd),
        .flags    (flags),
        .cr_d     (cr_d),
        .is_write (is_write)
    );

    crf_read_mux #(
        .NUM_FIELDS (NUM_FIELDS),
        .GPR_W      (GPR_W)
    ) u_rd (
        .cr_q   (cr_q),
        .op     (op),
        .sel_oh (sel_oh),
        .result (result)
    );

    // Condition register: clear on reset, update when qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (wr_en && is_write) begin
            cr_q <= cr_d;
        end
    end

    // Assertion support: previous register value and per-field change flags.
    always_ff @(posedge clk) begin
        cr_prev_q <= cr_q;
    end

    genvar n;
    generate
        for (n = 0; n < NUM_FIELDS; n++) begin : g_diff
            localparam int HI = CR_W - 1 - CRF_FIELD_W * n;
            assign fld_diff[n] = |(cr_q[HI -: CRF_FIELD_W] ^ cr_prev_q[HI -: CRF_FIELD_W]);
        end
    endgenerate

    // Field of the register at a variable index, MSB-first numbering.
    function automatic logic [CRF_FIELD_W-1:0] field_at(
        input logic [CR_W-1:0] v, input logic [IDX_W-1:0] i);
        return v[CR_W - 1 - CRF_FIELD_W * int'(i) -: CRF_FIELD_W];
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cr_q == '0)); // R1

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cr_q)); // R8

    AST_HOLD_READ_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd2 && op_sel != 3'd4) |=> $stable(cr_q)); // R8

    AST_ONE_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_sel == 3'd1) |=> ($countones(fld_diff) <= 1)); // R3

    AST_FLAG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_sel == 3'd4) |=>
        (field_at(cr_q, $past(fld_idx)) ==
         {$past(flag_ov), $past(flag_ov32), $past(flag_ca), $past(flag_ca32)})); // R7

    AST_FULL_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3) |-> (result[GPR_W-1:CR_W] == '0)); // R6

    AST_ONE_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && fld_mask == '0) |-> (result == '0)); // R5

    AST_WRITE_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd4) |-> (result == '0)); // R8

endmodule

// File: tb/sim_crf_xfer_unit.sv
`timescale 1ns/1ps
module sim_crf_xfer_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  op_sel;
    logic [7:0]  fld_mask;
    logic [2:0]  fld_idx;
    logic [63:0] src_opnd;
    logic        flag_ov, flag_ov32, flag_ca, flag_ca32;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] model_cr;

    always #2 clk = ~clk;

    crf_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_sel(op_sel),
        .fld_mask(fld_mask), .fld_idx(fld_idx), .src_opnd(src_opnd),
        .flag_ov(flag_ov), .flag_ov32(flag_ov32), .flag_ca(flag_ca),
        .flag_ca32(flag_ca32), .result(result)
    );

    function automatic int first_set(logic [7:0] m);
        for (int n = 0; n < 8; n++) if (m[7-n]) return n;
        return 8;
    endfunction

    function automatic logic [63:0] exp_result(logic [2:0] op, logic [7:0] m, logic [31:0] cr);
        logic [63:0] r = '0;
        int n;
        case (op)
            3'd2: begin
                n = first_set(m);
                if (n < 8) r[31-4*n -: 4] = cr[31-4*n -: 4];
            end
            3'd3: r = {32'd0, cr};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] exp_next(logic [2:0] op, logic we, logic [7:0] m,
        logic [2:0] ix, logic [63:0] s, logic [3:0] fl, logic [31:0] cr);
        logic [31:0] c = cr;
        int n;
        if (!we) return c;
        case (op)
            3'd0: for (int k = 0; k < 8; k++) if (m[7-k]) c[31-4*k -: 4] = s[31-4*k -: 4];
            3'd1: begin
                n = first_set(m);
                if (n == 8) n = 7;
                c[31-4*n -: 4] = s[31-4*n -: 4];
            end
            3'd4: c[31-4*int'(ix) -: 4] = fl;
            default: c = cr;
        endcase
        return c;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one op for one cycle: check the result before the edge, then update the model.
    task automatic run_op(string req, logic [2:0] op, logic we, logic [7:0] m,
        logic [2:0] ix, logic [63:0] s, logic [3:0] fl);
        @(negedge clk);
        op_sel = op; wr_en = we; fld_mask = m; fld_idx = ix; src_opnd = s;
        {flag_ov, flag_ov32, flag_ca, flag_ca32} = fl;
        #1;
        check(req, result, exp_result(op, m, model_cr));
        @(posedge clk);
        model_cr = exp_next(op, we, m, ix, s, fl, model_cr);
    endtask

    // Full read of the register, checked against the model.
    task automatic peek(string req);
        run_op(req, 3'd3, 1'b1, $urandom, $urandom, {$urandom, $urandom}, $urandom);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        rst_n = 1'b0; wr_en = 1'b0; op_sel = 3'd3; fld_mask = '0; fld_idx = '0;
        src_opnd = '0; {flag_ov, flag_ov32, flag_ca, flag_ca32} = '0;
        model_cr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 reset read", result, 64'd0);
        rst_n = 1'b1;

        // R2: all fields, then a sparse mask
        run_op("R2", 3'd0, 1'b1, 8'hFF, 3'd0, 64'hDEAD_BEEF_1234_5678, 4'h0);
        peek("R2 full mask");
        run_op("R2", 3'd0, 1'b1, 8'hA5, 3'd0, 64'h0000_0000_ABCD_EF01, 4'h0);
        peek("R2 sparse mask");
        // R9: same-cycle read sees old value; write seen next cycle
        run_op("R9 write", 3'd0, 1'b1, 8'h0F, 3'd0, 64'h0000_0000_FFFF_FFFF, 4'h0);
        run_op("R9 read after write", 3'd3, 1'b0, 8'h00, 3'd0, '0, 4'h0);
        // R3: priority and default
        run_op("R3", 3'd1, 1'b1, 8'h00, 3'd0, 64'h0000_0000_0000_0009, 4'h0);
        peek("R3 empty mask writes field 7");
        run_op("R3", 3'd1, 1'b1, 8'h81, 3'd0, 64'h0000_0000_3000_0000, 4'h0);
        peek("R3 field 0 wins");
        run_op("R3", 3'd1, 1'b1, 8'h01, 3'd0, 64'h0000_0000_0000_0006, 4'h0);
        peek("R3 only field 7");
        run_op("R3", 3'd1, 1'b1, 8'h16, 3'd0, 64'h0000_0000_5555_5555, 4'h0);
        peek("R3 field 3 wins");
        // R4/R5
        run_op("R4 single read field 0", 3'd2, 1'b1, 8'hFF, 3'd0, '1, 4'h0);
        run_op("R4 single read field 6", 3'd2, 1'b1, 8'h03, 3'd0, '1, 4'h0);
        run_op("R5 single read empty mask", 3'd2, 1'b1, 8'h00, 3'd0, '1, 4'h0);
        // R6 handled by peek; R7 every index and flag order
        for (int i = 0; i < 8; i++) begin
            run_op("R7", 3'd4, 1'b1, 8'hFF, 3'(i), '1, 4'(4'h8 >> (i % 4)));
            peek("R7 flag copy");
        end
        // R8: no write when disabled, unused codes
        run_op("R8 we low", 3'd0, 1'b0, 8'hFF, 3'd0, '1, 4'h0);
        peek("R8 held with we low");
        for (int c = 5; c < 8; c++) begin
            run_op("R8 unused code", 3'(c), 1'b1, 8'hFF, 3'd2, '1, 4'hF);
            peek("R8 held on unused code");
        end
        run_op("R8 flag copy we low", 3'd4, 1'b0, 8'h00, 3'd3, '0, 4'hF);
        peek("R8 flag copy we low");

        // Constrained random mix
        for (int it = 0; it < 600; it++) begin
            logic [2:0] op = 3'($urandom % 8);
            logic we = ($urandom % 4) != 0;
            logic [7:0] m;
            case ($urandom % 4)
                0: m = 8'h00;
                1: m = 8'h80 >> ($urandom % 8);
                2: m = 8'hFF;
                default: m = 8'($urandom);
            endcase
            run_op("R2/R3/R4/R6/R7/R8 random", op, we, m, 3'($urandom), {$urandom, $urandom}, 4'($urandom));
            if (it % 3 == 0) peek("R6 random full read");
        end

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0; op_sel = 3'd3; wr_en = 1'b1;
        @(posedge clk); model_cr = '0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 mid-run reset", result, 64'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule